// File: doc/BRIEF.md
# Four-Lane Aligned Sample Fetcher

The block reads a run of 16-bit samples, or coefficients, from a circular buffer held in memory as 64-bit words of four samples each, and streams them out four lanes per beat. Each request gives the sample index of the first tap and a tap count. Taps are taken in descending memory order, so tap t reads sample (start - t) mod DEPTH. The memory port accepts only whole-word reads. When the start index is not on a word edge, the block still reads the whole word that holds it and flags the lanes that fall outside the run as invalid. This costs no extra read compared with single-sample access, and a downstream multiply-accumulate stage ignores the invalid lanes.

The buffer depth DEPTH is a multiple of four, so no word crosses the wrap point. Word reads step downward and wrap from word 0 to word DEPTH/4-1. Within each beat the lane order is reversed relative to memory, so output lane k carries the tap with the larger index. Every beat carries a per-lane valid mask. Only the first and last beats can have invalid lanes. The last beat is flagged.

The controller is a four-state machine:
- IDLE accepts a request. A legal request moves it to ISSUE; an illegal one is dropped and it stays in IDLE.
- ISSUE drives the first word read and always moves to LAND.
- LAND captures the returned word, reversed, together with its mask and last flag, and always moves to OFFER.
- OFFER presents the beat. When the beat is accepted it goes back to IDLE on the last beat. Otherwise it issues the next read in the same cycle and moves to LAND.

Top module: `fetch4_stream`

## Requirements
- R1: After reset, out_valid and mem_rd_en are low and req_ready is high.
- R2: A request is taken when req_valid and req_ready are both high. req_ready stays low from the cycle after acceptance until the last beat has been accepted, and is never high while out_valid is high.
- R3: A request with req_len of 0, req_len above DEPTH, or req_addr of DEPTH or more is dropped. It causes no memory read and no beat, and req_ready stays high.
- R4: The first word read is req_addr/4. Each later read is the previous word index minus one, and word 0 is followed by word DEPTH/4-1.
- R5: A request makes exactly B = ceil((3 - req_addr%4 + req_len)/4) word reads and B output beats.
- R6: Output lane k, in bits [16k+15:16k] of out_data, carries memory lane 3-k, in bits [16(3-k)+15:16(3-k)] of the word read for that beat. This holds for valid and invalid lanes alike.
- R7: Mask bit k is 1 exactly when 4b+k-L lies in [0, req_len), where b is the beat number counted from 0 and L = 3 - req_addr%4. Every beat has at least one valid lane. Beats other than the first and last are all ones. A last beat that is not the first has lane 0 valid.
- R8: A valid lane k of beat b holds sample (req_addr - (4b+k-L)) mod DEPTH.
- R9: While out_valid is high and out_ready is low, out_valid, out_data, out_mask and out_last hold their values.
- R10: out_last is high on the final beat of a request and on no other beat.
- R11: A word read after the first is issued only in the cycle in which the current beat is accepted. No read is issued while a beat waits for out_ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request strobe |
| req_ready | output | 1 | Block idle, request can be taken |
| req_addr | input | $clog2(DEPTH) | Sample index of tap 0 |
| req_len | input | $clog2(DEPTH+1) | Number of taps |
| mem_rd_en | output | 1 | Word read strobe; data valid one cycle later |
| mem_rd_addr | output | $clog2(DEPTH)-2 | Word index |
| mem_rd_data | input | 64 | Word read data, lane j in bits [16j+15:16j] |
| out_valid | output | 1 | Beat available |
| out_ready | input | 1 | Consumer takes the beat |
| out_data | output | 64 | Four lanes, tap order reversed from memory |
| out_mask | output | 4 | Per-lane valid flags, bit k for lane k |
| out_last | output | 1 | Final beat of the request |

## Verification
The bench builds the block with DEPTH = 24. That gives six words, which is not a power of two, so the word pointer has to wrap explicitly from word 0 to word 5, and start indices 24 to 31 on the 5-bit address port become reachable illegal values. With this small depth a full-length run of 24 taps fits in a few beats, which places a first beat, several all-ones middle beats and a masked last beat in one request. Each of the four start alignments appears, some runs use a stalling consumer, and some runs wrap across the buffer end.

// File: rtl/fetch4_pkg.sv
package fetch4_pkg;
    localparam int LANES    = 4;
    localparam int SAMPLE_W = 16;
    localparam int WORD_W   = LANES * SAMPLE_W;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ISSUE,
        ST_LAND,
        ST_OFFER
    } fetch_state_e;
endpackage

// File: rtl/fetch4_plan.sv
// Request decode: first word, leading dead lanes, beat count, legality.
module fetch4_plan #(
    parameter int DEPTH = 64,
    parameter int AW    = 6,
    parameter int LEN_W = 7,
    parameter int NB_W  = 5,
    parameter int PW    = 8
) (
    input  logic [AW-1:0]    addr,
    input  logic [LEN_W-1:0] len,
    output logic [AW-3:0]    first_word,
    output logic [1:0]       lead,
    output logic [NB_W-1:0]  nbeats,
    output logic             ok
);
    logic [PW-1:0] total;

    always_comb begin
        first_word = addr[AW-1:2];
        lead       = ~addr[1:0];
        total      = PW'(lead) + PW'(len);
        nbeats     = NB_W'((total + PW'(3)) >> 2);
        ok         = (len != '0) && (len <= LEN_W'(DEPTH))
                     && ({1'b0, addr} < (AW+1)'(DEPTH));
    end
endmodule

// File: rtl/fetch4_mask.sv
// Per-lane valid flags for one beat.
module fetch4_mask #(
    parameter int LANES = 4,
    parameter int LEN_W = 7,
    parameter int NB_W  = 5,
    parameter int PW    = 8
) (
    input  logic [NB_W-1:0]  bidx,
    input  logic [1:0]       lead,
    input  logic [LEN_W-1:0] len,
    output logic [LANES-1:0] mask
);
    logic [PW-1:0] hi_edge;
    assign hi_edge = PW'(lead) + PW'(len);

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        logic [PW-1:0] pos;
        assign pos     = (PW'(bidx) << 2) + PW'(k);
        assign mask[k] = (pos >= PW'(lead)) && (pos < hi_edge);
    end
endmodule

// File: rtl/fetch4_flip.sv
// Lane reversal: output lane k takes memory lane LANES-1-k.
module fetch4_flip #(
    parameter int LANES = 4,
    parameter int SW    = 16
) (
    input  logic [LANES*SW-1:0] word_in,
    output logic [LANES*SW-1:0] word_out
);
    for (genvar k = 0; k < LANES; k++) begin : g_flip
        assign word_out[k*SW +: SW] = word_in[(LANES-1-k)*SW +: SW];
    end
endmodule

// File: rtl/fetch4_stream.sv
module fetch4_stream
    import fetch4_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int AW    = $clog2(DEPTH),
    localparam int WAW   = AW - 2,
    localparam int NW    = DEPTH / 4,
    localparam int LEN_W = $clog2(DEPTH + 1),
    localparam int NB_W  = $clog2(DEPTH / 4 + 2),
    localparam int PW    = $clog2(DEPTH + 8) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [AW-1:0]     req_addr,
    input  logic [LEN_W-1:0]  req_len,
    output logic              mem_rd_en,
    output logic [WAW-1:0]    mem_rd_addr,
    input  logic [WORD_W-1:0] mem_rd_data,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [WORD_W-1:0] out_data,
    output logic [LANES-1:0]  out_mask,
    output logic              out_last
);
    fetch_state_e state, state_nx;

    logic [WAW-1:0]    wptr;
    logic [1:0]        lead_q;
    logic [LEN_W-1:0]  len_q;
    logic [NB_W-1:0]   nb_q;
    logic [NB_W-1:0]   bidx;
    logic [WORD_W-1:0] data_q;
    logic [LANES-1:0]  mask_q;
    logic              last_q;

    logic [WAW-1:0]    plan_word;
    logic [1:0]        plan_lead;
    logic [NB_W-1:0]   plan_nb;
    logic              plan_ok;
    logic [LANES-1:0]  beat_mask;
    logic [WORD_W-1:0] flipped;
    logic [WAW-1:0]    wptr_dec;

    fetch4_plan #(.DEPTH(DEPTH), .AW(AW), .LEN_W(LEN_W), .NB_W(NB_W), .PW(PW)) u_plan (
        .addr(req_addr), .len(req_len), .first_word(plan_word),
        .lead(plan_lead), .nbeats(plan_nb), .ok(plan_ok)
    );

    fetch4_mask #(.LANES(LANES), .LEN_W(LEN_W), .NB_W(NB_W), .PW(PW)) u_mask (
        .bidx(bidx), .lead(lead_q), .len(len_q), .mask(beat_mask)
    );

    fetch4_flip #(.LANES(LANES), .SW(SAMPLE_W)) u_flip (
        .word_in(mem_rd_data), .word_out(flipped)
    );

    assign wptr_dec = (wptr == '0) ? WAW'(NW - 1) : wptr - 1'b1;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (req_valid && plan_ok) state_nx = ST_ISSUE;
            ST_ISSUE: state_nx = ST_LAND;
            ST_LAND:  state_nx = ST_OFFER;
            ST_OFFER: if (out_ready) state_nx = last_q ? ST_IDLE : ST_LAND;
        endcase
    end

    // Outputs
    always_comb begin
        req_ready   = (state == ST_IDLE);
        out_valid   = (state == ST_OFFER);
        mem_rd_en   = (state == ST_ISSUE)
                      || ((state == ST_OFFER) && out_ready && !last_q);
        mem_rd_addr = wptr;
        out_data    = data_q;
        out_mask    = mask_q;
        out_last    = last_q;
    end

    // Request context, word pointer and beat register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wptr   <= '0;
            lead_q <= '0;
            len_q  <= '0;
            nb_q   <= '0;
            bidx   <= '0;
            data_q <= '0;
            mask_q <= '0;
            last_q <= 1'b0;
        end else begin
            if (state == ST_IDLE && req_valid && plan_ok) begin
                wptr   <= plan_word;
                lead_q <= plan_lead;
                len_q  <= req_len;
                nb_q   <= plan_nb;
                bidx   <= '0;
            end
            if (mem_rd_en) wptr <= wptr_dec;
            if (state == ST_LAND) begin
                data_q <= flipped;
                mask_q <= beat_mask;
                last_q <= (bidx == nb_q - 1'b1);
            end
            if (state == ST_OFFER && out_ready && !last_q) bidx <= bidx + 1'b1;
        end
    end

    // Checks
    logic [WAW-1:0] chk_prev;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         chk_prev <= '0;
        else if (mem_rd_en) chk_prev <= mem_rd_addr;
    end

    assert_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !req_ready);

    assert_word_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_en && state == ST_OFFER) |->
        mem_rd_addr == ((chk_prev == '0) ? WAW'(NW - 1) : chk_prev - 1'b1));

    assert_some_lane_R7: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> out_mask != '0);

    assert_middle_full_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && bidx != '0 && !out_last) |-> out_mask == '1);

    assert_last_lane0_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_last && bidx != '0) |-> out_mask[0]);

    assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=>
        (out_valid && $stable(out_data) && $stable(out_mask) && $stable(out_last)));

    assert_read_on_accept_R11: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |-> (!out_valid || out_ready));
endmodule

// File: tb/fetch4_stream_bench.sv
module fetch4_stream_bench;
    localparam int DEPTH = 24;
    localparam int AW    = $clog2(DEPTH);
    localparam int WAW   = AW - 2;
    localparam int NW    = DEPTH / 4;
    localparam int LEN_W = $clog2(DEPTH + 1);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic [AW-1:0]     req_addr = '0;
    logic [LEN_W-1:0]  req_len = '0;
    logic              mem_rd_en;
    logic [WAW-1:0]    mem_rd_addr;
    logic [63:0]       mem_rd_data = '0;
    logic              out_valid;
    logic              out_ready = 1'b0;
    logic [63:0]       out_data;
    logic [3:0]        out_mask;
    logic              out_last;

    int total_n = 0;
    int fail_n  = 0;
    int cyc     = 0;
    int bp_mode = 0;
    int rd_n    = 0;
    int beat_n  = 0;
    int hold_err = 0;
    int rd_log [0:31];
    logic [63:0] bt_data [0:15];
    logic [3:0]  bt_mask [0:15];
    logic        bt_last [0:15];
    logic        hold_pend = 1'b0;
    logic [63:0] hold_d;
    logic [3:0]  hold_m;

    always #2 clk = ~clk;

    fetch4_stream #(.DEPTH(DEPTH)) u_fetch4_stream (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_len(req_len), .mem_rd_en(mem_rd_en),
        .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data), .out_valid(out_valid),
        .out_ready(out_ready), .out_data(out_data), .out_mask(out_mask), .out_last(out_last)
    );

    function automatic logic [15:0] sval(int s);
        return 16'h5A00 ^ (16'(s) * 16'h0107);
    endfunction

    // Synchronous memory model with a read log
    always @(posedge clk) begin
        if (mem_rd_en) begin
            for (int j = 0; j < 4; j++) mem_rd_data[16*j +: 16] <= sval(4 * int'(mem_rd_addr) + j);
            if (rd_n < 32) rd_log[rd_n] = int'(mem_rd_addr);
            rd_n++;
        end
    end

    // Consumer: picks ready, records beats, watches holds
    always @(negedge clk) begin
        cyc++;
        if (hold_pend && (!out_valid || out_data != hold_d || out_mask != hold_m)) hold_err++;
        out_ready = (bp_mode == 0) ? 1'b1 : ((cyc % 3) != 0);
        hold_pend = out_valid && !out_ready;
        hold_d = out_data;
        hold_m = out_mask;
        if (out_valid && out_ready && beat_n < 16) begin
            bt_data[beat_n] = out_data;
            bt_mask[beat_n] = out_mask;
            bt_last[beat_n] = out_last;
            beat_n++;
        end
    end

    task automatic check(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
        total_n++;
        if (!ok) begin
            fail_n++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic run_req(int addr, int len, int bp);
        int lead, nb, w;
        logic [63:0] e_word, e_ord, vmask;
        logic [3:0] e_mask;
        @(negedge clk);
        rd_n = 0; beat_n = 0; hold_err = 0; bp_mode = bp;
        req_valid = 1'b1; req_addr = AW'(addr); req_len = LEN_W'(len);
        @(negedge clk);
        req_valid = 1'b0;
        check(req_ready == 1'b0, "R2 busy after accept", 64'(req_ready), 64'd0);
        lead = 3 - addr % 4;
        nb = (lead + len + 3) / 4;
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            if (req_ready && beat_n >= nb) break;
        end
        check(beat_n == nb, "R5 beat count", 64'(beat_n), 64'(nb));
        check(rd_n == nb, "R5 read count", 64'(rd_n), 64'(nb));
        for (int b = 0; b < nb && b < beat_n; b++) begin
            w = ((addr / 4) - b + 2 * NW) % NW;
            check(rd_log[b] == w, "R4 word index", 64'(rd_log[b]), 64'(w));
            e_word = '0; e_ord = '0; vmask = '0; e_mask = '0;
            for (int k = 0; k < 4; k++) begin
                int tap = 4 * b + k - lead;
                e_word[16*k +: 16] = sval(4 * w + 3 - k);
                if (tap >= 0 && tap < len) begin
                    e_mask[k] = 1'b1;
                    vmask[16*k +: 16] = 16'hFFFF;
                    e_ord[16*k +: 16] = sval(((addr - tap) % DEPTH + DEPTH) % DEPTH);
                end
            end
            check(bt_data[b] == e_word, "R6 lane reversal", bt_data[b], e_word);
            check(bt_mask[b] == e_mask, "R7 lane mask", 64'(bt_mask[b]), 64'(e_mask));
            check((bt_data[b] & vmask) == e_ord, "R8 tap order", bt_data[b] & vmask, e_ord);
            check(bt_last[b] == (b == nb - 1), "R10 last flag", 64'(bt_last[b]), 64'(b == nb - 1));
        end
        check(hold_err == 0, "R9 hold under stall", 64'(hold_err), 64'd0);
        bp_mode = 0;
    endtask

    task automatic run_reject(int addr, int len);
        @(negedge clk);
        rd_n = 0; beat_n = 0;
        req_valid = 1'b1; req_addr = AW'(addr); req_len = LEN_W'(len);
        @(negedge clk);
        req_valid = 1'b0;
        repeat (6) @(negedge clk);
        check(rd_n == 0, "R3 no read on reject", 64'(rd_n), 64'd0);
        check(beat_n == 0, "R3 no beat on reject", 64'(beat_n), 64'd0);
        check(req_ready == 1'b1, "R3 ready after reject", 64'(req_ready), 64'd1);
    endtask

    task automatic test_reset();
        check(out_valid == 1'b0, "R1 out_valid at reset", 64'(out_valid), 64'd0);
        check(mem_rd_en == 1'b0, "R1 mem_rd_en at reset", 64'(mem_rd_en), 64'd0);
        check(req_ready == 1'b1, "R1 req_ready at reset", 64'(req_ready), 64'd1);
    endtask

    task automatic test_stall_reads();
        // R11: no read while a beat waits; sampled across a stalled run
        int bad = 0;
        @(negedge clk);
        rd_n = 0; beat_n = 0; bp_mode = 2;
        req_valid = 1'b1; req_addr = AW'(23); req_len = LEN_W'(16);
        @(negedge clk);
        req_valid = 1'b0;
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (mem_rd_en && out_valid && !out_ready) bad++;
            if (req_ready) break;
        end
        check(bad == 0, "R11 read only on accept", 64'(bad), 64'd0);
        check(rd_n == 4, "R11 read total", 64'(rd_n), 64'd4);
        bp_mode = 0;
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        test_reset();
        run_req(11, 8, 0);    // aligned, lead 0
        run_req(8, 5, 0);     // lead 3
        run_req(13, 7, 0);    // lead 2
        run_req(6, 10, 0);    // lead 1, wraps word 0 -> 5
        run_req(0, 1, 0);     // single tap
        run_req(2, DEPTH, 1); // full length under stalls
        run_req(19, 9, 1);
        test_stall_reads();
        run_reject(5, 0);
        run_reject(5, DEPTH + 1);
        run_reject(DEPTH + 3, 4);
        $display("%0d/%0d checks passed", total_n - fail_n, total_n);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        fail_n++;
        total_n++;
        $display("FAIL watchdog expired act=%0d exp=0", cyc);
        $display("%0d/%0d checks passed", total_n - fail_n, total_n);
        $finish;
    end
endmodule